// File: doc/BRIEF.md
# Memory Test Access Port

This block is the serial test port of a synchronous SRAM. A tester clocks it with a test clock, steers it with a mode-select input and feeds serial data in. Results come back on a serial output that the block drives only while data is actually shifting. A sixteen-state controller walks the standard instruction and data scan paths. A 3-bit instruction register chooses which data register sits between serial in and serial out: a 1-bit bypass stage, a 32-bit identification word, or a 75-bit boundary chain that snapshots the memory's I/O ring.

Two instructions make the memory's output drivers go to high impedance through the `out_disable` pin. The first captures the ring and floats the drivers. The second is a sample-only instruction that also floats them. A third instruction samples the ring without touching the memory. None of the instructions has a preload or drive-out stage, so shifted data never reaches the pins. Unused instruction codes fall back to the bypass stage and have no side effects.

Top module: `sram_tap`

## Requirements
- R1: `trst_n` low at a rising test-clock edge puts the controller in its reset state. At the following falling edge the active instruction becomes IDCODE (001), which releases `out_disable` and keeps `tdo_en` low.
- R2: In Capture-IR the instruction shift stage loads 001. It leaves on `tdo` least significant bit first: 1, 0, 0.
- R3: IDCODE (001) selects the 32-bit ID word, shifted out bit 0 first. With default parameters the word is built as follows: bit 0 = 1; bits 11:1 = vendor code 00000101100; bits 17:12 = device code 101010; bits 22:18 = width code 00011; bits 27:23 = depth code 00111; bits 31:28 = revision 0000.
- R4: BYPASS (111) selects a single stage that captures 0. `tdo` then repeats `tdi` delayed by one shift.
- R5: Codes 011, 101 and 110 behave as BYPASS and leave `out_disable` low.
- R6: Codes 000, 010 and 100 select the 75-bit boundary chain. The chain loads `pin_in` in Capture-DR and shifts out bit 0 first. A later capture overwrites whatever was shifted in, because there is no update stage.
- R7: `out_disable` is high exactly while the active instruction is 000 or 010. A new instruction becomes active only at the falling edge in Update-IR. Until that edge the previous value holds.
- R8: `tdo` and `tdo_en` change only on the falling test-clock edge. `tdo_en` is high only in Shift-IR and Shift-DR, and `tdo` carries the low bit of the selected shift stage.
- R9: Five consecutive rising edges with `tms` high reach the reset state from any state. This reloads IDCODE and releases `out_disable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, sampled on the test clock |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data in |
| pin_in | input | BSR_LEN | Live I/O ring values taken by the boundary chain |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Drive enable for `tdo`; low means the pad floats |
| out_disable | output | 1 | Forces the memory output drivers to high impedance |

## Verification
Several properties are checked on every clock edge. These cover: the 001 capture pattern; the bypass stage capturing zero; the reset state being held after five high mode-select edges; `out_disable` changing only in Update-IR or reset; and `tdo_en` being low outside the shift states. Other behaviour can only be shown by the bench's scenarios. This includes the exact bit order of the ID word and the boundary snapshot, the one-shift delay of bypass, the reserved codes acting as bypass, and `out_disable` holding until the Update-IR fall. It also includes the sample-only instruction recapturing the ring instead of keeping shifted data, and recovery through both the reset pin and the five-ones path.

// File: rtl/sram_tap_pkg.sv
// Shared types for the memory test port: controller states, instruction
// codes and data-register selection. Assumes a 3-bit instruction register.
package sram_tap_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR,
        ST_EX2_DR, ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR,
        ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DSEL_BYP, DSEL_ID, DSEL_BSR
    } dr_sel_e;

    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [10:0]     VENDOR_CODE = 11'b00000101100;

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state test controller. Moves on each rising test clock edge.
// Assumes trst_n is a synchronous active-low reset sampled on tck.
module tap_fsm
    import sram_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;
    logic [2:0] ones_cnt;

    // Next state from the current state and tms.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
            default:   nxt = ST_TLR;
        endcase
    end

    // State register with synchronous reset into the reset state.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end

    // Saturating count of consecutive high tms edges, used by the checks.
    always_ff @(posedge tck) begin
        if (!trst_n || !tms) ones_cnt <= '0;
        else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_cnt == 3'd5) |-> (state == ST_TLR)); // R9
    AST_TLR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR && tms) |=> (state == ST_TLR)); // R9

endmodule

// File: rtl/tap_ir.sv
// Instruction register: a shift stage on the rising edge and an active
// instruction loaded on the falling edge in Update-IR. Decodes the selected
// data register and the output-disable request. Unused codes act as bypass.
module tap_ir
    import sram_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       ir_lsb,
    output dr_sel_e    sel,
    output logic       out_disable
);

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_act;

    // Capture the fixed pattern, or shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_sh <= OP_IDCODE;
        else if (state == ST_CAP_IR) ir_sh <= 3'b001;
        else if (state == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Active instruction: IDCODE in reset, new value at the Update-IR fall.
    always_ff @(negedge tck) begin
        if (!trst_n || state == ST_TLR) ir_act <= OP_IDCODE;
        else if (state == ST_UPD_IR)    ir_act <= ir_sh;
    end

    // Decode the data-register select and the driver disable.
    always_comb begin
        unique case (ir_act)
            OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: sel = DSEL_BSR;
            OP_IDCODE:                        sel = DSEL_ID;
            default:                          sel = DSEL_BYP;
        endcase
        out_disable = (ir_act == OP_EXTEST) || (ir_act == OP_SAMPLEZ);
    end

    assign ir_lsb = ir_sh[0];

    AST_CAPIR_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (ir_sh == 3'b001)); // R2
    AST_DIS_RISE_AT_UPD: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(out_disable) |-> (state == ST_UPD_IR)); // R7
    AST_DIS_FALL_AT_UPD: assert property (@(posedge tck) disable iff (!trst_n)
        $fell(out_disable) |-> (state == ST_UPD_IR || state == ST_TLR)); // R7

endmodule

// File: rtl/tap_dr.sv
// Data registers: 1-bit bypass, ID word and boundary chain. Only the selected
// register captures in Capture-DR and shifts in Shift-DR. The boundary chain
// has no update latch, so shifted data never reaches any pin.
module tap_dr
    import sram_tap_pkg::*;
#(
    parameter int          BSR_LEN  = 75,
    parameter logic [31:0] ID_VALUE = 32'h1
) (
    input  logic               tck,
    input  logic               trst_n,
    input  tap_state_e         state,
    input  dr_sel_e            sel,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               dr_lsb
);

    localparam int ID_W = 32;

    logic               byp;
    logic [ID_W-1:0]    idr;
    logic [BSR_LEN-1:0] bsr;
    logic               cap, sft;

    assign cap = (state == ST_CAP_DR);
    assign sft = (state == ST_SH_DR);

    // Bypass stage: captures zero, shifts tdi.
    always_ff @(posedge tck) begin
        if (!trst_n)                      byp <= 1'b0;
        else if (sel == DSEL_BYP && cap)  byp <= 1'b0;
        else if (sel == DSEL_BYP && sft)  byp <= tdi;
    end

    // ID word: captures the constant, shifts toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)                     idr <= ID_VALUE;
        else if (sel == DSEL_ID && cap)  idr <= ID_VALUE;
        else if (sel == DSEL_ID && sft)  idr <= {tdi, idr[ID_W-1:1]};
    end

    // Boundary chain: snapshots the I/O ring, shifts toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)                      bsr <= '0;
        else if (sel == DSEL_BSR && cap)  bsr <= pin_in;
        else if (sel == DSEL_BSR && sft)  bsr <= {tdi, bsr[BSR_LEN-1:1]};
    end

    // Low bit of whichever register is selected.
    always_comb begin
        unique case (sel)
            DSEL_ID:  dr_lsb = idr[0];
            DSEL_BSR: dr_lsb = bsr[0];
            default:  dr_lsb = byp;
        endcase
    end

    AST_BYP_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
        (cap && sel == DSEL_BYP) |=> (byp == 1'b0)); // R4
    AST_ID_PRESENCE_BIT: assert property (@(posedge tck) disable iff (!trst_n)
        (cap && sel == DSEL_ID) |=> (idr[0] == 1'b1)); // R3

endmodule

// File: rtl/sram_tap.sv
// Top of the memory test port. Joins controller, instruction register and
// data registers. Drives tdo and its enable on the falling test clock edge.
// Assumes the pad outside floats tdo whenever tdo_en is low.
module sram_tap
    import sram_tap_pkg::*;
#(
    parameter int         BSR_LEN    = 75,
    parameter logic [3:0] REV_CODE   = 4'b0000,
    parameter logic [4:0] DEPTH_CODE = 5'b00111,
    parameter logic [4:0] WIDTH_CODE = 5'b00011,
    parameter logic [5:0] DEV_CODE   = 6'b101010
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic               out_disable
);

    localparam logic [31:0] ID_VALUE =
        {REV_CODE, DEPTH_CODE, WIDTH_CODE, DEV_CODE, VENDOR_CODE, 1'b1};

    tap_state_e state;
    dr_sel_e    sel;
    logic       ir_lsb, dr_lsb;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
    );

    tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
        .ir_lsb(ir_lsb), .sel(sel), .out_disable(out_disable)
    );

    tap_dr #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dr (
        .tck(tck), .trst_n(trst_n), .state(state), .sel(sel), .tdi(tdi),
        .pin_in(pin_in), .dr_lsb(dr_lsb)
    );

    // Serial output and its enable, retimed to the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
            tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
        end
    end

    AST_TDO_EN_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == ST_SH_IR || state == ST_SH_DR) |-> !tdo_en); // R8

endmodule

// File: tb/sim_sram_tap.sv
module sim_sram_tap;

    localparam int BSR_LEN = 75;
    localparam logic [31:0] EXP_ID =
        {4'b0000, 5'b00111, 5'b00011, 6'b101010, 11'b00000101100, 1'b1};

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [BSR_LEN-1:0] pin_in = '0;
    logic tdo, tdo_en, out_disable;

    int total = 0;
    int bad = 0;
    logic exp_q[$];
    string req_q[$];

    always #4 tck = ~tck;

    sram_tap u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_en(tdo_en), .out_disable(out_disable)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One test clock: inputs change after the falling edge.
    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
    endtask

    // Driver: load an instruction from Run-Test/Idle; expects 1,0,0 out (R2).
    task automatic load_ir(input logic [2:0] code, output logic od_before);
        exp_q.push_back(1'b1); req_q.push_back("R2");
        exp_q.push_back(1'b0); req_q.push_back("R2");
        exp_q.push_back(1'b0); req_q.push_back("R2");
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        step(0, code[0]); step(0, code[1]); step(1, code[2]);
        step(1, 0);
        @(posedge tck); #1;
        od_before = out_disable;
        step(0, 0);
    endtask

    // Driver: scan a data register, pushing the expected output bits.
    task automatic shift_dr(input int len, input logic [127:0] din,
                            input logic [127:0] expv, input string req);
        for (int i = 0; i < len; i++) begin
            exp_q.push_back(expv[i]);
            req_q.push_back(req);
        end
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < len; i++) step((i == len - 1), din[i]);
        step(1, 0); step(0, 0);
    endtask

    // Monitor: pops one expected bit for each falling edge that drives tdo.
    initial begin
        forever begin
            @(negedge tck);
            #2;
            if (tdo_en === 1'b1) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R8 actual=tdo_en 1 expected=tdo_en 0 (no shift queued)");
                end else begin
                    logic e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    if (tdo !== e) begin
                        bad++;
                        $display("FAIL %s actual=%b expected=%b", r, tdo, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge tck);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic odb;
        logic [127:0] pat;
        logic [2:0] rsv [3];
        rsv[0] = 3'b011; rsv[1] = 3'b101; rsv[2] = 3'b110;

        // R1: reset state
        repeat (3) @(posedge tck);
        @(negedge tck); #2;
        chk(tdo_en, 1'b0, "R1");
        chk(out_disable, 1'b0, "R1");
        trst_n = 1'b1;
        step(0, 0);
        // R3: IDCODE active after reset
        shift_dr(32, 128'h0, {96'h0, EXP_ID}, "R3");

        // R4: bypass delays tdi by one shift
        load_ir(3'b111, odb);
        chk(out_disable, 1'b0, "R4");
        shift_dr(4, 128'hB, {124'h0, 4'b0110}, "R4");
        shift_dr(6, 128'h2D, {122'h0, 6'b011010}, "R4");

        // R5: reserved codes act as bypass with no disable
        foreach (rsv[k]) begin
            load_ir(rsv[k], odb);
            chk(out_disable, 1'b0, "R5");
            shift_dr(3, 128'h5, {125'h0, 3'b010}, "R5");
        end

        // R6/R7: capture-and-float instruction
        pat = 128'h5A5_F00F_1234_C3C3_9E37;
        pin_in = pat[BSR_LEN-1:0];
        load_ir(3'b000, odb);
        chk(odb, 1'b0, "R7");
        chk(out_disable, 1'b1, "R7");
        shift_dr(BSR_LEN, {128{1'b1}}, pat, "R6");
        chk(out_disable, 1'b1, "R7");

        // R6/R7: sample-and-float instruction
        pat = 128'h3C_0FF0_AAAA_5555_1357;
        pin_in = pat[BSR_LEN-1:0];
        load_ir(3'b010, odb);
        chk(odb, 1'b1, "R7");
        chk(out_disable, 1'b1, "R7");
        shift_dr(BSR_LEN, 128'h0, pat, "R6");

        // R6/R7: sample only; recapture overrides shifted data
        pat = 128'h7FF_0001_8421_DEAD_BEEF;
        pin_in = pat[BSR_LEN-1:0];
        load_ir(3'b100, odb);
        chk(odb, 1'b1, "R7");
        chk(out_disable, 1'b0, "R7");
        shift_dr(BSR_LEN, {128{1'b1}}, pat, "R6");
        shift_dr(BSR_LEN, 128'h0, pat, "R6");
        chk(out_disable, 1'b0, "R6");

        // R9: five high tms edges reach reset
        load_ir(3'b000, odb);
        chk(out_disable, 1'b1, "R9");
        repeat (5) step(1, 0);
        step(0, 0);
        chk(out_disable, 1'b0, "R9");
        shift_dr(32, 128'h0, {96'h0, EXP_ID}, "R9");

        // R1: reset pin during an active float instruction
        load_ir(3'b010, odb);
        chk(out_disable, 1'b1, "R1");
        trst_n = 1'b0;
        step(1, 0); step(1, 0);
        @(negedge tck); #2;
        chk(out_disable, 1'b0, "R1");
        chk(tdo_en, 1'b0, "R1");
        trst_n = 1'b1;
        step(0, 0);
        shift_dr(32, 128'h0, {96'h0, EXP_ID}, "R1");

        // R8: every queued bit was driven
        repeat (2) @(posedge tck);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R8 actual=%0d left expected=0 left", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule